// File: doc/BRIEF.md
# Script Controller Host Register Write Decoder

This block receives host register writes for a script-driven bus controller and turns them into register updates and command pulses. A host write carries 1, 2 or 4 bytes. The block splits a wider write into byte lanes in little-endian order: the least significant byte goes to the addressed offset and each following byte goes to the next offset. All lanes of one write are decoded in the same cycle. Each byte offset selects a register with its own write mask, or one of three byte-lane word banks: the next-address word, the script pointer and the scratch array.

Some writes carry side effects. These are starting the script engine, raising an abort interrupt, requesting a soft reset, waking the engine from a wait, raising the general-purpose timer interrupt at once, and asking for a re-evaluation of the interrupt line. The engine drives its running and waiting flags into the block. The engine also pulses an input that sets the stored interrupt-on-the-fly flag. A combinational byte readback port shows the stored state.

Top module: `scr_hostreg_wr`

## Requirements
- R1: Size code 0, 1 and 2 write 1, 2 and 4 bytes. Byte k of `wr_data_i` (bits 8k+7..8k) lands at offset `wr_addr_i`+k. The next-address word sits at 0x28..0x2B, least significant byte at 0x28.
- R2: The script pointer is a 32-bit word at 0x2C..0x2F, least significant byte at 0x2C. A byte write replaces only its own byte.
- R3: A write to 0x2F produces `start_o` only when bit 0 (manual start) of the mode register at 0x38 is 0 and `eng_running_i` is 0.
- R4: A write to the status register 0x14 stores bits 7..4 and keeps bits 3..0. Bit 7 set raises `abort_o`. Bit 6 set raises `soft_rst_o`.
- R5: `fly_set_i` sets status bit 2. A status write with bit 2 set clears it and raises `irq_eval_o`.
- R6: A status write with bit 5 set while `eng_waiting_i` is 1 raises `wake_o` and `start_o` and copies the next-address word into the script pointer. With `eng_waiting_i` 0 this bit has no side effect.
- R7: A write to the DMA control register 0x3B stores the value with bits 6 and 2 cleared. Bit 2 set while `eng_running_i` is 0 raises `start_o`.
- R8: The destination-ID register 0x06 and the test register 0x1B keep only bits 3..0 of the written value.
- R9: Writes to 0x0C..0x0F change nothing, raise no pulse and raise no error. These offsets read back 0.
- R10: The scratch array holds word 0 at 0x34..0x37 and word n at 0x58+4n..0x5B+4n for n = 1..17, so 0x5C..0x9F map to words 1..17. The byte lane is offset bits 1..0. A byte write changes only that byte.
- R11: A write to 0x49 with a nonzero value in bits 3..0 raises `gp_timer_o`. Any other value raises nothing.
- R12: Writes to 0x39, 0x40 and 0x41 store the full byte and raise `irq_eval_o`.
- R13: A byte lane aimed at an unmapped offset is dropped and raises `wr_err_o`.
- R14: Every pulse output is high for exactly the one cycle after the write that causes it. Pulses caused by one write appear together in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one write per cycle |
| wr_addr_i | input | 8 | Byte offset of the lowest written byte |
| wr_size_i | input | 2 | 0 byte, 1 half-word, 2 word |
| wr_data_i | input | 8*BUS_BYTES | Write data, little-endian |
| eng_running_i | input | 1 | Script engine is executing |
| eng_waiting_i | input | 1 | Script engine waits for a host signal |
| fly_set_i | input | 1 | Engine sets the interrupt-on-the-fly flag |
| rd_addr_i | input | 8 | Readback offset |
| rd_data_o | output | 8 | Readback byte |
| start_o | output | 1 | Start script pulse |
| abort_o | output | 1 | Abort interrupt pulse |
| soft_rst_o | output | 1 | Soft reset pulse |
| wake_o | output | 1 | Leave wait state pulse |
| gp_timer_o | output | 1 | Immediate timer interrupt pulse |
| irq_eval_o | output | 1 | Re-evaluate interrupt line pulse |
| wr_err_o | output | 1 | Unmapped byte dropped |

## Verification
The bench builds the block with its default parameters: BUS_BYTES = 4 and SCR_WORDS = 18. With the full four-lane width, a single write can cover a whole pointer, next-address or scratch word. It can also straddle a mapped and an unmapped offset, or reach the status register together with its neighbours. Eighteen scratch words put the top of the array at 0x9F, so the bench can write the last scratch word and probe 0xA0, the first unmapped offset above it.

// File: rtl/scr_reg_pkg.sv
`timescale 1ns/1ps
package scr_reg_pkg;

  // Offsets whose position the behaviour depends on
  localparam logic [7:0] A_DEST   = 8'h06;
  localparam logic [7:0] A_RO_LO  = 8'h0C;
  localparam logic [7:0] A_RO_HI  = 8'h0F;
  localparam logic [7:0] A_STAT   = 8'h14;
  localparam logic [7:0] A_TEST3  = 8'h1B;
  localparam logic [7:0] A_NEXT   = 8'h28;
  localparam logic [7:0] A_PTR    = 8'h2C;
  localparam logic [7:0] A_PTR_MS = 8'h2F;
  localparam logic [7:0] A_SCR0   = 8'h34;
  localparam logic [7:0] A_MODE   = 8'h38;
  localparam logic [7:0] A_DIRQ   = 8'h39;
  localparam logic [7:0] A_DCTL   = 8'h3B;
  localparam logic [7:0] A_SIRQ0  = 8'h40;
  localparam logic [7:0] A_SIRQ1  = 8'h41;
  localparam logic [7:0] A_TMR1   = 8'h49;
  localparam logic [7:0] A_SCRX   = 8'h58;

  // Bit positions
  localparam int unsigned ST_ABORT  = 7;
  localparam int unsigned ST_RESET  = 6;
  localparam int unsigned ST_SIGNAL = 5;
  localparam int unsigned ST_FLY    = 2;
  localparam int unsigned MD_MANUAL = 0;
  localparam int unsigned DC_FLUSH  = 6;
  localparam int unsigned DC_KICK   = 2;

  typedef struct packed {
    logic       valid;
    logic [7:0] off;
    logic [7:0] data;
  } byte_wr_t;

  typedef struct packed {
    logic start;
    logic abort;
    logic srst;
    logic wake;
    logic gtimer;
    logic irq_eval;
    logic err;
  } fx_t;

  typedef struct packed {
    logic       hit;
    logic [7:0] idx;
    logic [1:0] lane;
  } bank_loc_t;

  // Word bank locator: word 0 at base_a, words first_b..words-1 at base_b+4n
  function automatic bank_loc_t bank_locate(input logic [7:0] off,
                                            input int unsigned base_a,
                                            input int unsigned base_b,
                                            input int unsigned first_b,
                                            input int unsigned words);
    bank_loc_t   loc;
    int unsigned o;
    o        = 32'(off);
    loc      = '0;
    loc.lane = off[1:0];
    if (o >= base_a && o < base_a + 4) begin
      loc.hit = 1'b1;
      loc.idx = 8'd0;
    end else if (words > first_b && o >= base_b + 4 * first_b &&
                 o < base_b + 4 * words) begin
      loc.hit = 1'b1;
      loc.idx = 8'((o - base_b) >> 2);
    end
    return loc;
  endfunction

endpackage

// File: rtl/scr_byte_split.sv
`timescale 1ns/1ps
module scr_byte_split
  import scr_reg_pkg::*;
#(
  parameter int unsigned BUS_BYTES = 4
) (
  input  logic                           wr_en_i,
  input  logic [7:0]                     wr_addr_i,
  input  logic [1:0]                     wr_size_i,
  input  logic [8*BUS_BYTES-1:0]         wr_data_i,
  output byte_wr_t [BUS_BYTES-1:0]       lanes_o
);

  for (genvar i = 0; i < BUS_BYTES; i++) begin : g_lane
    // smallest size code that still covers lane i
    localparam int unsigned LSZ = (i == 0) ? 0 : $clog2(i + 1);
    assign lanes_o[i].valid = wr_en_i && (32'(wr_size_i) >= LSZ);
    assign lanes_o[i].off   = wr_addr_i + 8'(i);
    assign lanes_o[i].data  = wr_data_i[8*i +: 8];
  end

endmodule

// File: rtl/scr_word_bank.sv
`timescale 1ns/1ps
module scr_word_bank
  import scr_reg_pkg::*;
#(
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned WORDS     = 1,
  parameter int unsigned BASE_A    = 0,
  parameter int unsigned BASE_B    = 0,
  parameter int unsigned FIRST_B   = 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  byte_wr_t [BUS_BYTES-1:0]   lanes_i,
  input  logic                       load_i,
  input  logic [31:0]                load_val_i,
  output logic [WORDS-1:0][31:0]     words_o,
  output logic [BUS_BYTES-1:0]       hit_o
);

  logic [WORDS-1:0][31:0] words_q, words_d;
  logic [WORDS-1:0]       word_en;
  bank_loc_t              loc;
  logic                   touch;

  // next state: a whole-word load first, byte lanes on top
  always_comb begin
    words_d = words_q;
    word_en = '0;
    hit_o   = '0;
    loc     = '0;
    if (load_i) begin
      words_d[0] = load_val_i;
      word_en[0] = 1'b1;
    end
    for (int i = 0; i < BUS_BYTES; i++) begin
      loc = bank_locate(lanes_i[i].off, BASE_A, BASE_B, FIRST_B, WORDS);
      if (lanes_i[i].valid && loc.hit) begin
        hit_o[i] = 1'b1;
        for (int w = 0; w < WORDS; w++) begin
          if (loc.idx == 8'(w)) begin
            words_d[w][{loc.lane, 3'b000} +: 8] = lanes_i[i].data;
            word_en[w] = 1'b1;
          end
        end
      end
    end
  end

  for (genvar w = 0; w < WORDS; w++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        words_q[w] <= '0;
      end else if (word_en[w]) begin
        words_q[w] <= words_d[w];
      end
    end
  end

  assign words_o = words_q;
  assign touch   = load_i | (|hit_o);

  // R2
  bank_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(touch) |-> $stable(words_q));

endmodule

// File: rtl/scr_hostreg_wr.sv
`timescale 1ns/1ps
module scr_hostreg_wr
  import scr_reg_pkg::*;
#(
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned SCR_WORDS = 18
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [7:0]              wr_addr_i,
  input  logic [1:0]              wr_size_i,
  input  logic [8*BUS_BYTES-1:0]  wr_data_i,
  input  logic                    eng_running_i,
  input  logic                    eng_waiting_i,
  input  logic                    fly_set_i,
  input  logic [7:0]              rd_addr_i,
  output logic [7:0]              rd_data_o,
  output logic                    start_o,
  output logic                    abort_o,
  output logic                    soft_rst_o,
  output logic                    wake_o,
  output logic                    gp_timer_o,
  output logic                    irq_eval_o,
  output logic                    wr_err_o
);

  localparam int unsigned SCR_BASE_A = 32'(A_SCR0);
  localparam int unsigned SCR_BASE_B = 32'(A_SCRX);
  localparam logic [7:0]  DC_MASK    = ~(8'(1 << DC_FLUSH) | 8'(1 << DC_KICK));

  byte_wr_t [BUS_BYTES-1:0] lanes;
  logic [BUS_BYTES-1:0]     nxt_hit, ptr_hit, scr_hit;
  logic [0:0][31:0]         nxt_w, ptr_w;
  logic [SCR_WORDS-1:0][31:0] scr_w;
  logic                     wake_hit;

  // control registers
  logic [3:0] dest_q, dest_d, test3_q, test3_d, stat_hi_q, stat_hi_d;
  logic       fly_q, fly_d;
  logic [7:0] mode_q, mode_d, dirq_q, dirq_d, dctl_q, dctl_d;
  logic [7:0] sirq0_q, sirq0_d, sirq1_q, sirq1_d;
  logic       ctl_en;
  fx_t        fx_d, fx_q;
  logic [7:0] v;
  logic       fly_clr;

  scr_byte_split #(.BUS_BYTES(BUS_BYTES)) u_split (
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_size_i(wr_size_i),
    .wr_data_i(wr_data_i),
    .lanes_o  (lanes)
  );

  scr_word_bank #(.BUS_BYTES(BUS_BYTES), .WORDS(1), .BASE_A(32'(A_NEXT)),
                  .BASE_B(0), .FIRST_B(1)) u_next (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lanes_i   (lanes),
    .load_i    (1'b0),
    .load_val_i(32'd0),
    .words_o   (nxt_w),
    .hit_o     (nxt_hit)
  );

  scr_word_bank #(.BUS_BYTES(BUS_BYTES), .WORDS(1), .BASE_A(32'(A_PTR)),
                  .BASE_B(0), .FIRST_B(1)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lanes_i   (lanes),
    .load_i    (wake_hit),
    .load_val_i(nxt_w[0]),
    .words_o   (ptr_w),
    .hit_o     (ptr_hit)
  );

  scr_word_bank #(.BUS_BYTES(BUS_BYTES), .WORDS(SCR_WORDS), .BASE_A(SCR_BASE_A),
                  .BASE_B(SCR_BASE_B), .FIRST_B(1)) u_scr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .lanes_i   (lanes),
    .load_i    (1'b0),
    .load_val_i(32'd0),
    .words_o   (scr_w),
    .hit_o     (scr_hit)
  );

  // lane decode: masks and side effects, all lanes in one cycle
  always_comb begin
    dest_d    = dest_q;
    test3_d   = test3_q;
    stat_hi_d = stat_hi_q;
    mode_d    = mode_q;
    dirq_d    = dirq_q;
    dctl_d    = dctl_q;
    sirq0_d   = sirq0_q;
    sirq1_d   = sirq1_q;
    fx_d      = '0;
    wake_hit  = 1'b0;
    fly_clr   = 1'b0;
    v         = '0;
    for (int i = 0; i < BUS_BYTES; i++) begin
      if (lanes[i].valid) begin
        v = lanes[i].data;
        case (lanes[i].off) inside
          A_DEST:  dest_d = v[3:0];
          [A_RO_LO:A_RO_HI]: ;
          A_STAT: begin
            stat_hi_d = v[7:4];
            if (v[ST_ABORT]) fx_d.abort = 1'b1;
            if (v[ST_RESET]) fx_d.srst  = 1'b1;
            if (v[ST_FLY]) begin
              fly_clr       = 1'b1;
              fx_d.irq_eval = 1'b1;
            end
            if (v[ST_SIGNAL] && eng_waiting_i) begin
              wake_hit   = 1'b1;
              fx_d.wake  = 1'b1;
              fx_d.start = 1'b1;
            end
          end
          A_TEST3: test3_d = v[3:0];
          A_MODE:  mode_d  = v;
          A_DIRQ: begin
            dirq_d        = v;
            fx_d.irq_eval = 1'b1;
          end
          A_DCTL: begin
            dctl_d = v & DC_MASK;
            if (v[DC_KICK] && !eng_running_i) fx_d.start = 1'b1;
          end
          A_SIRQ0: begin
            sirq0_d       = v;
            fx_d.irq_eval = 1'b1;
          end
          A_SIRQ1: begin
            sirq1_d       = v;
            fx_d.irq_eval = 1'b1;
          end
          A_TMR1: begin
            if (|v[3:0]) fx_d.gtimer = 1'b1;
          end
          A_PTR_MS: begin
            if (!mode_q[MD_MANUAL] && !eng_running_i) fx_d.start = 1'b1;
          end
          default: begin
            if (!(nxt_hit[i] | ptr_hit[i] | scr_hit[i])) fx_d.err = 1'b1;
          end
        endcase
      end
    end
    fly_d = fly_q;
    if (fly_clr)   fly_d = 1'b0;
    if (fly_set_i) fly_d = 1'b1;
  end

  assign ctl_en = wr_en_i | fly_set_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dest_q    <= '0;
      test3_q   <= '0;
      stat_hi_q <= '0;
      fly_q     <= 1'b0;
      mode_q    <= '0;
      dirq_q    <= '0;
      dctl_q    <= '0;
      sirq0_q   <= '0;
      sirq1_q   <= '0;
    end else if (ctl_en) begin
      dest_q    <= dest_d;
      test3_q   <= test3_d;
      stat_hi_q <= stat_hi_d;
      fly_q     <= fly_d;
      mode_q    <= mode_d;
      dirq_q    <= dirq_d;
      dctl_q    <= dctl_d;
      sirq0_q   <= sirq0_d;
      sirq1_q   <= sirq1_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fx_q <= '0;
    end else begin
      fx_q <= fx_d;
    end
  end

  assign start_o    = fx_q.start;
  assign abort_o    = fx_q.abort;
  assign soft_rst_o = fx_q.srst;
  assign wake_o     = fx_q.wake;
  assign gp_timer_o = fx_q.gtimer;
  assign irq_eval_o = fx_q.irq_eval;
  assign wr_err_o   = fx_q.err;

  // readback
  bank_loc_t rl_nxt, rl_ptr, rl_scr;
  always_comb begin
    rl_nxt    = bank_locate(rd_addr_i, 32'(A_NEXT), 0, 1, 1);
    rl_ptr    = bank_locate(rd_addr_i, 32'(A_PTR), 0, 1, 1);
    rl_scr    = bank_locate(rd_addr_i, SCR_BASE_A, SCR_BASE_B, 1, SCR_WORDS);
    rd_data_o = 8'h00;
    case (rd_addr_i)
      A_DEST:  rd_data_o = {4'h0, dest_q};
      A_STAT:  rd_data_o = {stat_hi_q, 1'b0, fly_q, 2'b00};
      A_TEST3: rd_data_o = {4'h0, test3_q};
      A_MODE:  rd_data_o = mode_q;
      A_DIRQ:  rd_data_o = dirq_q;
      A_DCTL:  rd_data_o = dctl_q;
      A_SIRQ0: rd_data_o = sirq0_q;
      A_SIRQ1: rd_data_o = sirq1_q;
      default: begin
        if (rl_nxt.hit) rd_data_o = nxt_w[0][{rl_nxt.lane, 3'b000} +: 8];
        if (rl_ptr.hit) rd_data_o = ptr_w[0][{rl_ptr.lane, 3'b000} +: 8];
        if (rl_scr.hit) begin
          for (int w = 0; w < SCR_WORDS; w++) begin
            if (rl_scr.idx == 8'(w)) rd_data_o = scr_w[w][{rl_scr.lane, 3'b000} +: 8];
          end
        end
      end
    endcase
  end

  // R3
  start_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_o |-> $past(wr_en_i));

  // R6
  wake_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (start_o && $past(eng_waiting_i)));

  // R6
  wake_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (ptr_w[0] == $past(nxt_w[0])));

  // R13
  err_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_err_o |-> $past(wr_en_i));

endmodule

// File: tb/scr_hostreg_wr_tb.sv
`timescale 1ns/1ps
module scr_hostreg_wr_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [7:0]  wr_addr_i;
  logic [1:0]  wr_size_i;
  logic [31:0] wr_data_i;
  logic        eng_running_i, eng_waiting_i, fly_set_i;
  logic [7:0]  rd_addr_i;
  logic [7:0]  rd_data_o;
  logic        start_o, abort_o, soft_rst_o, wake_o, gp_timer_o, irq_eval_o, wr_err_o;

  int n_chk  = 0;
  int n_fail = 0;
  // captured pulses {start,abort,srst,wake,gtimer,irq_eval,err}
  logic [6:0] cap;

  always #4 clk_i = ~clk_i;

  scr_hostreg_wr dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_size_i(wr_size_i), .wr_data_i(wr_data_i), .eng_running_i(eng_running_i),
    .eng_waiting_i(eng_waiting_i), .fly_set_i(fly_set_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .start_o(start_o), .abort_o(abort_o),
    .soft_rst_o(soft_rst_o), .wake_o(wake_o), .gp_timer_o(gp_timer_o),
    .irq_eval_o(irq_eval_o), .wr_err_o(wr_err_o)
  );

  function automatic logic [6:0] pulses();
    return {start_o, abort_o, soft_rst_o, wake_o, gp_timer_o, irq_eval_o, wr_err_o};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_size_i = sz; wr_data_i = d;
    @(negedge clk_i);
    cap = pulses();
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    rd_addr_i = a;
    #1;
    v = rd_data_o;
  endtask

  task automatic chk_rd(input string req, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] v;
    rd(a, v);
    chk(req, 32'(v), 32'(exp));
  endtask

  task automatic t_reset();
    chk("R14 reset pulses", 32'(pulses()), 32'h0);
    chk_rd("R2 reset ptr", 8'h2F, 8'h00);
    chk_rd("R10 reset scratch", 8'h5C, 8'h00);
  endtask

  task automatic t_split();
    wr(8'h28, 2'd2, 32'h11223344);           // R1 word write
    chk("R1 word no pulse", 32'(cap), 32'h0);
    chk_rd("R1 byte0", 8'h28, 8'h44);
    chk_rd("R1 byte1", 8'h29, 8'h33);
    chk_rd("R1 byte3", 8'h2B, 8'h11);
    wr(8'h5C, 2'd1, 32'hFFFFBEEF);           // R1 half write
    chk_rd("R1 half lo", 8'h5C, 8'hEF);
    chk_rd("R1 half hi", 8'h5D, 8'hBE);
    chk_rd("R1 half not beyond", 8'h5E, 8'h00);
  endtask

  task automatic t_ptr_lane();
    eng_running_i = 1'b1;
    wr(8'h2C, 2'd2, 32'hA0B0C0D0);
    wr(8'h2D, 2'd0, 32'h00000055);
    chk_rd("R2 lane0 kept", 8'h2C, 8'hD0);
    chk_rd("R2 lane1 new", 8'h2D, 8'h55);
    chk_rd("R2 lane2 kept", 8'h2E, 8'hB0);
    chk_rd("R2 lane3 kept", 8'h2F, 8'hA0);
    eng_running_i = 1'b0;
  endtask

  task automatic t_start_gate();
    wr(8'h2F, 2'd0, 32'h01);
    chk("R3 start idle", 32'(cap), 32'b1000000);
    eng_running_i = 1'b1;
    wr(8'h2F, 2'd0, 32'h02);
    chk("R3 no start running", 32'(cap), 32'h0);
    eng_running_i = 1'b0;
    wr(8'h38, 2'd0, 32'h01);
    wr(8'h2F, 2'd0, 32'h03);
    chk("R3 no start manual", 32'(cap), 32'h0);
    wr(8'h38, 2'd0, 32'h00);
    chk_rd("R3 ptr still written", 8'h2F, 8'h03);
  endtask

  task automatic t_status();
    wr(8'h14, 2'd0, 32'h80);
    chk("R4 abort", 32'(cap), 32'b0100000);
    chk_rd("R4 upper stored", 8'h14, 8'h80);
    wr(8'h14, 2'd0, 32'h40);
    chk("R4 soft reset", 32'(cap), 32'b0010000);
    wr(8'h14, 2'd0, 32'h30);
    chk("R6 signal no wait", 32'(cap), 32'h0);
    chk_rd("R4 nibble", 8'h14, 8'h30);
  endtask

  task automatic t_fly();
    @(negedge clk_i); fly_set_i = 1'b1;
    @(negedge clk_i); fly_set_i = 1'b0;
    chk_rd("R5 fly set", 8'h14, 8'h34);
    wr(8'h14, 2'd0, 32'h04);
    chk("R5 irq eval", 32'(cap), 32'b0000010);
    chk_rd("R5 fly cleared", 8'h14, 8'h00);
  endtask

  task automatic t_wake();
    eng_waiting_i = 1'b1;
    wr(8'h14, 2'd0, 32'h20);
    eng_waiting_i = 1'b0;
    chk("R6 wake+start", 32'(cap), 32'b1001000);
    chk_rd("R6 ptr b0", 8'h2C, 8'h44);
    chk_rd("R6 ptr b3", 8'h2F, 8'h11);
  endtask

  task automatic t_dctl();
    wr(8'h3B, 2'd0, 32'h45);
    chk("R7 start", 32'(cap), 32'b1000000);
    chk_rd("R7 masked", 8'h3B, 8'h01);
    eng_running_i = 1'b1;
    wr(8'h3B, 2'd0, 32'h04);
    eng_running_i = 1'b0;
    chk("R7 no start running", 32'(cap), 32'h0);
    chk_rd("R7 masked2", 8'h3B, 8'h00);
  endtask

  task automatic t_masks();
    wr(8'h06, 2'd0, 32'hFA);
    chk_rd("R8 dest", 8'h06, 8'h0A);
    wr(8'h1B, 2'd0, 32'h9C);
    chk_rd("R8 test3", 8'h1B, 8'h0C);
  endtask

  task automatic t_readonly();
    wr(8'h0C, 2'd2, 32'hFFFFFFFF);
    chk("R9 no effect", 32'(cap), 32'h0);
    for (int k = 0; k < 4; k++) chk_rd("R9 reads zero", 8'(8'h0C + k), 8'h00);
  endtask

  task automatic t_scratch();
    wr(8'h61, 2'd0, 32'h7E);
    chk_rd("R10 byte", 8'h61, 8'h7E);
    chk_rd("R10 lane0 kept", 8'h60, 8'h00);
    chk_rd("R10 next word", 8'h65, 8'h00);
    wr(8'h9C, 2'd2, 32'hCAFE0102);
    chk("R10 last word ok", 32'(cap), 32'h0);
    chk_rd("R10 last byte", 8'h9F, 8'hCA);
    wr(8'h34, 2'd2, 32'h0D0C0B0A);
    chk_rd("R10 word0", 8'h37, 8'h0D);
  endtask

  task automatic t_timer();
    wr(8'h49, 2'd0, 32'h03);
    chk("R11 timer", 32'(cap), 32'b0000100);
    wr(8'h49, 2'd0, 32'h50);
    chk("R11 no timer", 32'(cap), 32'h0);
  endtask

  task automatic t_irq_en();
    wr(8'h39, 2'd0, 32'h5A);
    chk("R12 dma irq eval", 32'(cap), 32'b0000010);
    chk_rd("R12 dma stored", 8'h39, 8'h5A);
    wr(8'h40, 2'd1, 32'h1234);
    chk("R12 bus irq eval", 32'(cap), 32'b0000010);
    chk_rd("R12 en0", 8'h40, 8'h34);
    chk_rd("R12 en1", 8'h41, 8'h12);
  endtask

  task automatic t_unmapped();
    wr(8'h3A, 2'd0, 32'h77);
    chk("R13 err", 32'(cap), 32'b0000001);
    chk_rd("R13 dropped", 8'h3A, 8'h00);
    wr(8'hA0, 2'd0, 32'h11);
    chk("R13 err above scratch", 32'(cap), 32'b0000001);
  endtask

  task automatic t_multi();
    @(negedge clk_i); fly_set_i = 1'b1;
    @(negedge clk_i); fly_set_i = 1'b0;
    wr(8'h14, 2'd0, 32'hC4);
    chk("R14 same cycle", 32'(cap), 32'b0110010);
    @(negedge clk_i);
    chk("R14 one cycle", 32'(pulses()), 32'h0);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_size_i = '0; wr_data_i = '0;
    eng_running_i = 1'b0; eng_waiting_i = 1'b0; fly_set_i = 1'b0; rd_addr_i = '0;
    cap = '0;
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_split();
    t_ptr_lane();
    t_start_gate();
    t_status();
    t_fly();
    t_wake();
    t_dctl();
    t_masks();
    t_readonly();
    t_scratch();
    t_timer();
    t_irq_en();
    t_unmapped();
    t_multi();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule